// File: doc/BRIEF.md
# Retriggerable Digital One-Shot

This block is a clocked pulse generator. A small down-counter sets how long the output pulse lasts. When the block is triggered, the counter is loaded with a programmable width value. The counter then counts down once per clock, and the output stays high for as long as the counter holds a nonzero value. The pulse width in clock cycles is therefore equal to the width value that was loaded.

The block has two trigger modes, chosen by a mode pin.

- **Edge (retriggerable) mode.** A rising edge on the trigger input reloads the counter, even in the middle of a pulse. Each new edge stretches the pulse so that it ends a full width after the most recent edge. An edge is detected when the trigger is 1 now and its copy registered on the previous clock is 0.
- **Level (non-retriggerable) mode.** The trigger is level-sensitive. It is looked at only while the counter is idle at zero, so a trigger that arrives during a pulse has no effect.

All pins are plain control signals. There is no data stream and no handshake. The trigger is expected to be synchronous to the clock already; apart from the single register used for edge detection, there is no synchroniser.

Top module: `one_shot_pulser`

## Requirements
- R1: While reset is asserted, `pulse_out` is 0. Reset clears both the counter and the stored previous trigger. As a result, in edge mode a trigger that is already high when reset is released counts as a rising edge on the first clock.
- R2: In edge mode (`retrig_en`=1), a clock edge that sees `trig_in`=1 while the previous sample was 0 loads the counter with `width_val`. `pulse_out` rises right after that clock edge and stays high for exactly `width_val` cycles.
- R3: In edge mode, holding `trig_in` high produces only one pulse, because two consecutive clocks never both detect an edge.
- R4: In edge mode, a new rising edge during a pulse reloads the counter with `width_val`. The pulse then ends `width_val` cycles after the most recent edge.
- R5: In level mode (`retrig_en`=0), `trig_in` has no effect while a pulse is in progress. The counter keeps decrementing by one per clock, so the pulse length is unchanged.
- R6: In level mode, a clock that sees `trig_in`=1 while the counter is zero loads `width_val`. If `trig_in` is held high, this gives repeated pulses of `width_val` high cycles, each followed by one low cycle.
- R7: A `width_val` of 0 produces no pulse in either mode.
- R8: `width_val` is sampled only at the moment the counter loads. Changing it during a pulse does not change that pulse's length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | 1 | Trigger, synchronous to `clk` |
| retrig_en | input | 1 | 1 = edge/retriggerable mode, 0 = level/non-retriggerable mode |
| width_val | input | CNT_W (4) | Pulse width in clock cycles, loaded on a trigger |
| pulse_out | output | 1 | High while the width counter is nonzero |

## Verification
The assertions check the following rules on every cycle:
- A load always takes `width_val`.
- An idle counter stays at zero unless it is loaded.
- A running counter steps down by exactly one unless it is reloaded.
- A rising edge is never detected on two clocks in a row.
- In level mode, a busy counter ignores the trigger.
- An idle trigger with zero width never raises the output.

Some behaviours appear only across a whole sequence of cycles, so only the bench scenarios can show them:
- the exact count of high cycles in a pulse;
- a pulse being stretched by a second edge;
- the one-cycle low gap between repeated level-mode pulses;
- the treatment of a trigger that is already high when reset is released.

// File: rtl/osp_pkg.sv
package osp_pkg;

  // Default width of the pulse-length counter.
  localparam int unsigned OSP_DEF_CNT_W = 4;

  // Trigger qualification modes, encoded as the mode pin value.
  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_EDGE  = 1'b1
  } trig_mode_e;

endpackage

// File: rtl/osp_edge_detect.sv
module osp_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic rise
);

  logic sig_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) sig_prev <= 1'b0;
    else        sig_prev <= sig_in;
  end

  assign rise = sig_in & ~sig_prev;

  AST_RISE_NOT_BACK2BACK: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R3

endmodule

// File: rtl/osp_width_counter.sv
module osp_width_counter #(
  parameter int unsigned CNT_W = osp_pkg::OSP_DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             busy
);

  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt <= CNT_ZERO;
    else if (load)            cnt <= load_val;
    else if (cnt != CNT_ZERO) cnt <= cnt - CNT_ONE;
  end

  assign busy = (cnt != CNT_ZERO);

  AST_LOAD_TAKES_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val))); // R2

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != CNT_ZERO) |=> (cnt == $past(cnt) - CNT_ONE)); // R8

  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt == CNT_ZERO) |=> (cnt == CNT_ZERO)); // R7

endmodule

// File: rtl/one_shot_pulser.sv
module one_shot_pulser #(
  parameter int unsigned CNT_W = osp_pkg::OSP_DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_in,
  input  logic             retrig_en,
  input  logic [CNT_W-1:0] width_val,
  output logic             pulse_out
);

  import osp_pkg::*;

  localparam logic [CNT_W-1:0] W_ZERO = '0;
  localparam logic [CNT_W-1:0] W_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  trig_mode_e       mode;
  logic             rise;
  logic             load;
  logic             busy;
  logic [CNT_W-1:0] cnt;

  assign mode = trig_mode_e'(retrig_en);

  osp_edge_detect u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_in (trig_in),
    .rise   (rise)
  );

  // Edge mode reloads on any rising edge; level mode arms only when idle.
  always_comb begin
    case (mode)
      TRIG_EDGE: load = rise;
      default:   load = trig_in & ~busy;
    endcase
  end

  osp_width_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (width_val),
    .cnt      (cnt),
    .busy     (busy)
  );

  assign pulse_out = busy;

  AST_RETRIG_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (retrig_en && rise) |=> (cnt == $past(width_val))); // R4

  AST_LEVEL_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!retrig_en && busy) |=> (cnt == $past(cnt) - W_ONE)); // R5

  AST_LEVEL_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (!retrig_en && trig_in && !busy) |=> (cnt == $past(width_val))); // R6

  AST_ZERO_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && width_val == W_ZERO) |=> !pulse_out); // R7

endmodule

// File: tb/one_shot_pulser_bench.sv
`timescale 1ns/1ps
module one_shot_pulser_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trig_in = 1'b1;
  logic       retrig_en = 1'b1;
  logic [3:0] width_val = 4'd2;
  logic       pulse_out;

  typedef struct {
    logic  exp;
    string tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  one_shot_pulser u_one_shot_pulser (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_in   (trig_in),
    .retrig_en (retrig_en),
    .width_val (width_val),
    .pulse_out (pulse_out)
  );

  // Driver: set inputs before a clock edge and queue the output expected after it.
  task automatic step(input logic t, input logic m, input logic [3:0] w,
                      input logic e, input string tag);
    @(negedge clk);
    trig_in   = t;
    retrig_en = m;
    width_val = w;
    sb_q.push_back('{e, tag});
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Monitor: compare one queued expectation just after each rising edge.
  initial begin
    exp_t it;
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        n_cmp++;
        if (pulse_out !== it.exp) begin
          n_bad++;
          $display("FAIL %s: pulse_out=%0b expected %0b at %0t", it.tag, pulse_out, it.exp, $time);
        end
      end
    end
  end

  initial begin
    // R1: output low throughout reset, even with trigger high
    repeat (3) @(negedge clk);
    n_cmp++;
    if (pulse_out !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: pulse_out=%0b expected 0 in reset", pulse_out);
    end
    // R1: released with trig high in edge mode -> counts as an edge, width 2
    @(negedge clk);
    rst_n = 1'b1;
    sb_q.push_back('{1'b1, "R1"});
    step(1, 1, 4'd2, 1, "R1");
    step(1, 1, 4'd2, 0, "R3");
    step(1, 1, 4'd2, 0, "R3");
    step(0, 1, 4'd2, 0, "R3");

    // R2 and R8: width 5, width_val changed during the pulse
    step(1, 1, 4'd5, 1, "R2");
    step(0, 1, 4'd15, 1, "R8");
    step(0, 1, 4'd1, 1, "R8");
    step(0, 1, 4'd0, 1, "R2");
    step(0, 1, 4'd9, 1, "R2");
    step(0, 1, 4'd5, 0, "R2");
    step(0, 1, 4'd5, 0, "R2");

    // R3: trigger held high long in edge mode, width 2
    step(1, 1, 4'd2, 1, "R3");
    step(1, 1, 4'd2, 1, "R3");
    step(1, 1, 4'd2, 0, "R3");
    step(1, 1, 4'd2, 0, "R3");
    step(0, 1, 4'd2, 0, "R3");

    // R4: second edge mid-pulse stretches it, width 3
    step(1, 1, 4'd3, 1, "R4");
    step(0, 1, 4'd3, 1, "R4");
    step(1, 1, 4'd3, 1, "R4");
    step(0, 1, 4'd3, 1, "R4");
    step(0, 1, 4'd3, 1, "R4");
    step(0, 1, 4'd3, 0, "R4");

    // R5: level mode, trigger during pulse ignored, width 4
    step(1, 0, 4'd4, 1, "R5");
    step(0, 0, 4'd4, 1, "R5");
    step(1, 0, 4'd4, 1, "R5");
    step(0, 0, 4'd4, 1, "R5");
    step(0, 0, 4'd4, 0, "R5");
    step(0, 0, 4'd4, 0, "R5");

    // R6: level mode held high, width 2 -> 1,1,0,1,1,0
    step(1, 0, 4'd2, 1, "R6");
    step(1, 0, 4'd2, 1, "R6");
    step(1, 0, 4'd2, 0, "R6");
    step(1, 0, 4'd2, 1, "R6");
    step(1, 0, 4'd2, 1, "R6");
    step(0, 0, 4'd2, 0, "R6");
    step(0, 0, 4'd2, 0, "R6");

    // R7: zero width in both modes
    step(1, 1, 4'd0, 0, "R7");
    step(0, 1, 4'd0, 0, "R7");
    step(1, 0, 4'd0, 0, "R7");
    step(1, 0, 4'd0, 0, "R7");
    step(0, 0, 4'd0, 0, "R7");

    // R2: full-scale width 15
    step(1, 1, 4'd15, 1, "R2");
    for (int i = 0; i < 14; i++) step(0, 1, 4'd15, 1, "R2");
    step(0, 1, 4'd15, 0, "R2");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all R): actual=hung expected=complete");
      report();
      $finish;
    end
  end

endmodule